// File: doc/BRIEF.md
# Receive Loss-of-Signal and Transmit Driver Silence Monitor

This block watches two serial bit streams. Each stream comes with its own bit-clock enable: one is the data recovered from the receive line, the other is the data seen on the transmit monitor tap. On the receive side it raises a loss-of-signal flag after a long unbroken run of zeros. That flag is released only when the recent traffic shows enough ones density. On the monitor side it raises a driver-silence flag after a shorter run of zeros, and drops that flag as soon as a mark appears.

Each flag change also produces a one-cycle event pulse, which an external interrupt latch can capture. A two-bit clock-source code tells a downstream glitch-free mux which clock feeds the receive clock output:
- the recovered clock in normal operation;
- the master clock while loss of signal is active;
- the transmit clock whenever local loopback is on, whatever the loss-of-signal state.

Received data passes straight through at all times. A synchronous reset command returns both monitors to their reset state.

Top module: `line_loss_monitor`

## Requirements
- R1: On an enabled cycle whose receive bit is zero, the receive zero count goes up by one. Loss of signal (`los`) goes high on the clock edge that takes in the 175th zero in a row.
- R2: An enabled receive bit of one sets the consecutive-zero count back to zero, so zeros taken in before that one do not count towards R1.
- R3: While `los` is high, it goes low only on an enabled bit after which the last 32 received bits hold at least 4 ones.
- R4: Release also requires that those 32 bits contain no run of more than 15 zeros. Bits taken in before a reset count as zeros.
- R5: `rx_data` always equals `rx_bit`, whether `los` is high or low.
- R6: The clock-source code `clk_sel` takes these values:
  - 2 (transmit clock) whenever `loop_local` is high;
  - otherwise 1 (master clock) while `los` is high;
  - otherwise 0 (recovered clock).
- R7: On the monitor stream, `drv_silent` goes high on the edge that takes in the 63rd enabled zero in a row.
- R8: An enabled monitor bit of one clears `drv_silent` on that edge and restarts the monitor zero count.
- R9: Both of these return every flag, counter and the release window to their reset state, with both flags 0:
  - `rst_n` low (asynchronous);
  - `soft_rst` high on a clock edge (synchronous, with priority over all bit inputs).
- R10: `los_evt` and `drv_evt` are each high for exactly the cycles in which the matching flag holds a value different from the one it held in the cycle before.
- R11: A cycle whose enable is low leaves that stream's counters, window and flag unchanged, whatever its data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset command |
| rx_bit_en | input | 1 | Receive bit qualifier |
| rx_bit | input | 1 | Recovered receive bit (1 = mark) |
| mon_bit_en | input | 1 | Monitor-tap bit qualifier |
| mon_bit | input | 1 | Monitor-tap bit (1 = mark) |
| loop_local | input | 1 | Local loopback active |
| rx_data | output | 1 | Receive data passed through |
| los | output | 1 | Loss-of-signal flag |
| drv_silent | output | 1 | Driver-silence flag |
| los_evt | output | 1 | One-cycle pulse on any `los` change |
| drv_evt | output | 1 | One-cycle pulse on any `drv_silent` change |
| clk_sel | output | 2 | Clock source: 0 recovered, 1 master, 2 transmit |

## Verification
The hardest case to reach from the ports is a release refused only because of a zero run. This needs a window that already holds four or more ones while a run of 16 or more zeros is still inside it, so that only R4 holds the flag high. The stimulus forces `los`, sends four marks in a row, then sends a sparse mark pattern. It samples the flag on the bit where the old zero run still reaches sixteen and on the next bit, where it no longer does. A long random phase then varies the density, the enable gaps, loopback and reset commands. A behavioural model checks every cycle.

// File: rtl/llm_pkg.sv
package llm_pkg;

  typedef enum logic [1:0] {
    CLK_RECOVERED = 2'd0,
    CLK_MASTER    = 2'd1,
    CLK_TRANSMIT  = 2'd2
  } clk_src_e;

  // Saturating increment towards lim.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // A run that reached max_run+1 zeros at a bit of age `age` still sits
  // wholly inside a win-bit window while age <= win-max_run-1.
  function automatic logic run_left_window(input int unsigned age, input int unsigned win,
                                           input int unsigned max_run);
    return age >= (win - max_run);
  endfunction

endpackage

// File: rtl/llm_zero_run.sv
module llm_zero_run
  import llm_pkg::*;
#(
  parameter int unsigned LIMIT = 175,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bit_en,
  input  logic          bit_in,
  output logic [CW-1:0] count,
  output logic          reached
);

  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (clr)
      cnt_nx = '0;
    else if (bit_en)
      cnt_nx = bit_in ? '0 : CW'(sat_inc(32'(cnt_q), LIMIT));
  end

  // This edge takes in a zero that makes the run LIMIT long (or keeps it there).
  assign reached = !clr && bit_en && !bit_in && (cnt_nx == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign count = cnt_q;

  a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));

  a_r2_mark_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && bit_in |=> cnt_q == '0);

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en && !clr |=> $stable(cnt_q));

endmodule

// File: rtl/llm_density_window.sv
module llm_density_window
  import llm_pkg::*;
#(
  parameter int unsigned WIN      = 32,
  parameter int unsigned MIN_ONES = 4,
  parameter int unsigned MAX_RUN  = 15,
  localparam int unsigned OW = $clog2(WIN + 1),
  localparam int unsigned RW = $clog2(MAX_RUN + 2),
  localparam int unsigned SW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bit_en,
  input  logic          bit_in,
  output logic [OW-1:0] ones,
  output logic          ok_nx
);

  logic [WIN-1:0] sr_q, sr_nx;
  logic [OW-1:0]  ones_q, ones_nx;
  logic [RW-1:0]  run_q, run_nx;      // trailing zero run, saturates at MAX_RUN+1
  logic [SW-1:0]  age_q, age_nx;      // bits since the run last exceeded MAX_RUN

  always_comb begin
    sr_nx   = sr_q;
    ones_nx = ones_q;
    run_nx  = run_q;
    age_nx  = age_q;
    if (clr) begin
      sr_nx   = '0;
      ones_nx = '0;
      run_nx  = RW'(MAX_RUN + 1);
      age_nx  = '0;
    end else if (bit_en) begin
      sr_nx   = {sr_q[WIN-2:0], bit_in};
      ones_nx = ones_q + OW'(bit_in) - OW'(sr_q[WIN-1]);
      run_nx  = bit_in ? '0 : RW'(sat_inc(32'(run_q), MAX_RUN + 1));
      age_nx  = (run_nx > RW'(MAX_RUN)) ? '0 : SW'(sat_inc(32'(age_q), WIN));
    end
  end

  assign ok_nx = (ones_nx >= OW'(MIN_ONES)) && run_left_window(32'(age_nx), WIN, MAX_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      ones_q <= '0;
      run_q  <= RW'(MAX_RUN + 1);
      age_q  <= '0;
    end else begin
      sr_q   <= sr_nx;
      ones_q <= ones_nx;
      run_q  <= run_nx;
      age_q  <= age_nx;
    end
  end

  assign ones = ones_q;

  a_r3_ones_match_window: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ones_q) == $countones(sr_q));

  a_r4_run_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(MAX_RUN + 1));

endmodule

// File: rtl/llm_event_flag.sv
module llm_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag,
  output logic chg
);

  logic flag_q, flag_nx, chg_q;

  always_comb begin
    flag_nx = flag_q;
    if (clr)      flag_nx = 1'b0;
    else if (set) flag_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      flag_q <= flag_nx;
      chg_q  <= flag_nx != flag_q;
    end
  end

  assign flag = flag_q;
  assign chg  = chg_q;

  a_r10_pulse_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q == ($rose(flag_q) || $fell(flag_q)));

endmodule

// File: rtl/line_loss_monitor.sv
module line_loss_monitor
  import llm_pkg::*;
#(
  parameter int unsigned LOS_ZEROS = 175,
  parameter int unsigned DRV_ZEROS = 63,
  parameter int unsigned WIN       = 32,
  parameter int unsigned MIN_ONES  = 4,
  parameter int unsigned MAX_RUN   = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       rx_bit_en,
  input  logic       rx_bit,
  input  logic       mon_bit_en,
  input  logic       mon_bit,
  input  logic       loop_local,
  output logic       rx_data,
  output logic       los,
  output logic       drv_silent,
  output logic       los_evt,
  output logic       drv_evt,
  output logic [1:0] clk_sel
);

  localparam int unsigned RXW = $clog2(LOS_ZEROS + 1);
  localparam int unsigned MNW = $clog2(DRV_ZEROS + 1);
  localparam int unsigned OW  = $clog2(WIN + 1);

  logic [RXW-1:0] rx_zeros;
  logic [MNW-1:0] mon_zeros;
  logic [OW-1:0]  win_ones;
  logic           rx_reached, mon_reached, win_ok_nx;
  logic           los_set, los_clr, drv_set, drv_clr;
  clk_src_e       src;

  llm_zero_run #(.LIMIT(LOS_ZEROS)) u_rx_run (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .bit_en(rx_bit_en), .bit_in(rx_bit),
    .count(rx_zeros), .reached(rx_reached));

  llm_zero_run #(.LIMIT(DRV_ZEROS)) u_mon_run (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .bit_en(mon_bit_en), .bit_in(mon_bit),
    .count(mon_zeros), .reached(mon_reached));

  llm_density_window #(.WIN(WIN), .MIN_ONES(MIN_ONES), .MAX_RUN(MAX_RUN)) u_window (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .bit_en(rx_bit_en), .bit_in(rx_bit),
    .ones(win_ones), .ok_nx(win_ok_nx));

  assign los_set = rx_reached;
  assign los_clr = soft_rst || (rx_bit_en && win_ok_nx);
  assign drv_set = mon_reached;
  assign drv_clr = soft_rst || (mon_bit_en && mon_bit);

  llm_event_flag u_los_flag (
    .clk(clk), .rst_n(rst_n), .set(los_set), .clr(los_clr), .flag(los), .chg(los_evt));

  llm_event_flag u_drv_flag (
    .clk(clk), .rst_n(rst_n), .set(drv_set), .clr(drv_clr), .flag(drv_silent), .chg(drv_evt));

  always_comb begin
    if (loop_local) src = CLK_TRANSMIT;
    else if (los)   src = CLK_MASTER;
    else            src = CLK_RECOVERED;
  end

  assign clk_sel = src;
  assign rx_data = rx_bit;

  a_r1_los_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_en && !rx_bit && !soft_rst && (rx_zeros == RXW'(LOS_ZEROS - 1)) |=> los);

  a_r3_release_has_density: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) && !$past(soft_rst) |-> win_ones >= OW'(MIN_ONES));

  a_r4_hold_without_window: assert property (@(posedge clk) disable iff (!rst_n)
    los && !soft_rst && !(rx_bit_en && win_ok_nx) |=> los);

  a_r6_loopback_wins: assert property (@(posedge clk) disable iff (!rst_n)
    loop_local |-> clk_sel == 2'd2);

  a_r7_drv_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    mon_bit_en && !mon_bit && !soft_rst && (mon_zeros == MNW'(DRV_ZEROS - 1)) |=> drv_silent);

  a_r8_mark_clears_drv: assert property (@(posedge clk) disable iff (!rst_n)
    mon_bit_en && mon_bit |=> !drv_silent);

  a_r9_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !los && !drv_silent);

endmodule

// File: tb/line_loss_monitor_tb.sv
module line_loss_monitor_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, rx_bit_en = 1'b0, rx_bit = 1'b0;
  logic mon_bit_en = 1'b0, mon_bit = 1'b0, loop_local = 1'b0;
  logic rx_data, los, drv_silent, los_evt, drv_evt;
  logic [1:0] clk_sel;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int zr_rx, zr_mon;
  bit win_q[$];
  bit los_m, drv_m, losc_m, drvc_m;

  always #10 clk = ~clk;

  line_loss_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_bit_en(rx_bit_en), .rx_bit(rx_bit),
    .mon_bit_en(mon_bit_en), .mon_bit(mon_bit), .loop_local(loop_local), .rx_data(rx_data),
    .los(los), .drv_silent(drv_silent), .los_evt(los_evt), .drv_evt(drv_evt), .clk_sel(clk_sel));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    zr_rx = 0; zr_mon = 0;
    win_q.delete();
    for (int i = 0; i < 32; i++) win_q.push_back(1'b0);
    los_m = 0; drv_m = 0;
  endtask

  function automatic int win_ones();
    int n = 0;
    foreach (win_q[i]) n += win_q[i];
    return n;
  endfunction

  function automatic int win_longest_zero_run();
    int best = 0, cur = 0;
    foreach (win_q[i]) begin
      cur = win_q[i] ? 0 : cur + 1;
      if (cur > best) best = cur;
    end
    return best;
  endfunction

  task automatic model_step();
    bit lo = los_m, dro = drv_m;
    if (soft_rst) model_reset();
    else begin
      if (rx_bit_en) begin
        zr_rx = rx_bit ? 0 : zr_rx + 1;
        win_q.push_back(rx_bit);
        void'(win_q.pop_front());
        if (!los_m && zr_rx >= 175) los_m = 1;
        else if (los_m && win_ones() >= 4 && win_longest_zero_run() <= 15) los_m = 0;
      end
      if (mon_bit_en) begin
        if (mon_bit) begin zr_mon = 0; drv_m = 0; end
        else begin zr_mon++; if (zr_mon >= 63) drv_m = 1; end
      end
    end
    losc_m = (los_m != lo);
    drvc_m = (drv_m != dro);
  endtask

  task automatic compare();
    int exp_sel = loop_local ? 2 : (los_m ? 1 : 0);
    chk(los == los_m, "R1 R2 R3 R4 R11 los", los, los_m);
    chk(drv_silent == drv_m, "R7 R8 R11 drv_silent", drv_silent, drv_m);
    chk(los_evt == losc_m, "R10 los_evt", los_evt, losc_m);
    chk(drv_evt == drvc_m, "R10 drv_evt", drv_evt, drvc_m);
    chk(int'(clk_sel) == exp_sel, "R6 clk_sel", clk_sel, exp_sel);
    chk(rx_data == rx_bit, "R5 rx_data", rx_data, rx_bit);
  endtask

  // One clock: inputs already set after a falling edge.
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic rx_send(input bit b, input int n);
    for (int i = 0; i < n; i++) begin
      rx_bit_en = 1; rx_bit = b; mon_bit_en = 0;
      tick();
    end
    rx_bit_en = 0;
  endtask

  task automatic mon_send(input bit b, input int n);
    for (int i = 0; i < n; i++) begin
      mon_bit_en = 1; mon_bit = b; rx_bit_en = 0;
      tick();
    end
    mon_bit_en = 0;
  endtask

  initial begin
    model_reset();
    losc_m = 0; drvc_m = 0;
    repeat (3) @(negedge clk);
    // R9: asynchronous reset state
    chk(los == 0 && drv_silent == 0 && los_evt == 0 && drv_evt == 0, "R9 reset flags",
        {los, drv_silent, los_evt, drv_evt}, 0);
    chk(clk_sel == 2'd0, "R6 reset clk_sel", clk_sel, 0);
    rst_n = 1;

    // R1 R2: 174 zeros, a mark, then a run that reaches 175
    rx_send(0, 174);
    chk(los == 0, "R1 174 zeros", los, 0);
    rx_send(1, 1);
    // R11: disabled cycles carrying marks must not restart the count
    for (int i = 0; i < 174; i++) begin
      rx_bit_en = 1; rx_bit = 0; tick();
      rx_bit_en = 0; rx_bit = (i % 3 == 0); tick();
    end
    chk(los == 0, "R2 R11 run after mark", los, 0);
    rx_send(0, 1);
    chk(los == 1, "R1 175th zero", los, 1);
    rx_send(1, 1);
    chk(los == 1 && rx_data == 1, "R5 mark passed during los", los, 1);

    // R3: three sparse ones then the fourth
    rx_send(0, 180);
    for (int k = 0; k < 3; k++) begin rx_send(1, 1); rx_send(0, 7); end
    chk(los == 1, "R3 three ones hold", los, 1);
    rx_send(1, 1);
    chk(los == 0, "R3 fourth one releases", los, 0);

    // R4: enough ones but an old zero run still in the window
    rx_send(0, 200);
    rx_send(1, 4);
    chk(los == 1, "R4 dense burst after long run", los, 1);
    for (int k = 0; k < 3; k++) begin rx_send(0, 3); rx_send(1, 1); end
    chk(los == 1, "R4 run of 16 still inside", los, 1);
    rx_send(0, 1);
    chk(los == 0, "R4 run left window", los, 0);

    // R6: loopback priority over los
    rx_send(0, 175);
    loop_local = 1; tick();
    chk(clk_sel == 2'd2, "R6 loopback over los", clk_sel, 2);
    loop_local = 0; tick();
    chk(clk_sel == 2'd1, "R6 master during los", clk_sel, 1);

    // R7 R8: monitor stream
    mon_send(0, 62);
    chk(drv_silent == 0, "R7 62 zeros", drv_silent, 0);
    mon_send(1, 1);
    mon_send(0, 63);
    chk(drv_silent == 1, "R7 63rd zero", drv_silent, 1);
    mon_send(1, 1);
    chk(drv_silent == 0, "R8 mark clears", drv_silent, 0);
    mon_send(0, 70);

    // R9 R10: soft reset with both flags high
    soft_rst = 1; rx_bit_en = 1; rx_bit = 0; mon_bit_en = 1; mon_bit = 0;
    tick();
    soft_rst = 0; rx_bit_en = 0; mon_bit_en = 0;
    chk(los == 0 && drv_silent == 0, "R9 soft reset clears", {los, drv_silent}, 0);
    chk(los_evt == 1 && drv_evt == 1, "R10 pulses on clear", {los_evt, drv_evt}, 3);
    tick();
    chk(los_evt == 0 && drv_evt == 0, "R10 single cycle", {los_evt, drv_evt}, 0);
    rx_send(0, 174);
    chk(los == 0, "R9 counter restarted", los, 0);
    rx_send(0, 1);
    chk(los == 1, "R1 after soft reset", los, 1);

    // random traffic with varying densities
    for (int blk = 0; blk < 24; blk++) begin
      int dens = (blk % 4 == 0) ? 0 : (blk % 4 == 1) ? 4 : (blk % 4 == 2) ? 12 : 40;
      for (int i = 0; i < 600; i++) begin
        rx_bit_en  = ($urandom % 4) != 0;
        rx_bit     = ($urandom % 100) < dens;
        mon_bit_en = ($urandom % 3) != 0;
        mon_bit    = ($urandom % 100) < (dens / 4);
        loop_local = ($urandom % 50) == 0;
        soft_rst   = ($urandom % 700) == 0;
        tick();
      end
    end
    soft_rst = 0; loop_local = 0; rx_bit_en = 0; mon_bit_en = 0;
    tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule